// File: doc/BRIEF.md
# Rational Sample Rate Converter

This block converts a signed fixed-point sample stream from one rate to another by a rational ratio L/M. The conversion happens in three steps. Each accepted input is spread over L filter-rate slots, and only the first of those slots holds the sample; the other slots hold zeros. A single lowpass FIR then filters that zero-filled stream. It acts as the interpolation filter and the anti-alias filter at once, so its cutoff must meet the tighter of the two limits, min(pi/L, pi/M). Its taps must also give a passband gain of L. Finally, only every M-th filtered value is kept and emitted. A 3/2 conversion, for example, uses L = 3 and M = 2.

Only one tap in every L can meet a nonzero stuffed sample. The datapath uses this: it keeps a short history of real input samples and computes each kept output as a polyphase dot product over ceil(NTAPS/L) taps, using one multiply-accumulate per cycle. The result is identical, bit for bit, to a full convolution over the zero-stuffed stream. A filter-rate slot counter modulo L*M decides which slots produce outputs. Outputs are rounded and saturated to the input word width.

Inputs arrive on a valid-qualified port with no back-pressure. The caller spaces them at least IN_GAP = L*(ceil(NTAPS/L)+1)+1 clock cycles apart.

Top module: `ratio_resampler`

## Requirements
- R1: While reset is asserted and after it is released, out_valid is 0 and out_data is 0 until the first output. Reset clears the sample history to zero and the slot counter to slot 0.
- R2: The filter sees the input stream with L-1 zeros inserted after every sample, convolved with all NTAPS taps (tap t at bits [t*CW +: CW] of COEFS). A single input of value A followed by zeros yields round(A*h[n]/2^SHIFT) at each kept slot n.
- R3: Filter-rate slot indices count from 0 at the first input after reset. Only slots n with n mod M = 0 are emitted, in increasing order of n.
- R4: An input accepted at filter-rate slot k*L produces exactly as many outputs as there are multiples of M in [k*L, k*L+L-1]. K inputs therefore produce ceil(K*L/M) outputs.
- R5: An accumulated sum s becomes floor((s + 2^(SHIFT-1)) / 2^SHIFT), so exact halves round toward positive infinity.
- R6: Rounded values above 2^(DW-1)-1 or below -2^(DW-1) are clamped to those limits.
- R7: in_valid is accepted only when the block is idle; inputs spaced IN_GAP or more cycles apart are always accepted. An in_valid pulse during a conversion is ignored and changes neither the outputs nor the slot phase.
- R8: For any input data the output sequence equals the reference built from explicit zero insertion, full convolution, decimation, rounding and saturation. This holds for ratios with L > M and with L < M, including tap counts that are not a multiple of L.
- R9: out_valid is high for exactly one cycle per output and never on two consecutive cycles.
- R10: The slot phase is carried across arbitrary idle time between inputs, so irregular input spacing gives the same output values as regular spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for each output sample |
| out_data | output | DW | Signed, rounded and saturated output sample |

## Verification
A slot counter that slips phase shows up at the ports in two ways. It changes how many outputs an input yields, and it selects the wrong polyphase branch. The second makes the very next output differ from the full-convolution reference, and the output count is off by the end of the sequence. A corrupted history register or a wrong coefficient index changes the value of the next output that reads that tap. An impulse input therefore exposes it within one input period. A missed accumulator clear adds the previous result into the next output, which shows as a wrong value as soon as any two outputs are produced.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    RR_IDLE = 2'd0,
    RR_SCAN = 2'd1,
    RR_MAC  = 2'd2
  } rr_state_e;

  // index width for a select over n entries, never below one bit
  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rr_seq.sv
module rr_seq
  import rr_pkg::*;
#(
  parameter int L   = 3,
  parameter int M   = 2,
  parameter int NPH = 4,
  localparam int PHW   = idx_w(L),
  localparam int TW    = idx_w(NPH),
  localparam int SLOTS = L * M,
  localparam int SW    = idx_w(SLOTS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           accept,
  output logic [PHW-1:0] phase,
  output logic [TW-1:0]  tap,
  output logic           mac_en,
  output logic           mac_first,
  output logic           mac_last
);

  rr_state_e      state_q, state_d;
  logic [SW-1:0]  slot_q, slot_d, slot_nx;
  logic [PHW-1:0] phase_q, phase_d;
  logic [TW-1:0]  tap_q, tap_d;
  logic           out_slot, last_phase, last_tap;

  always_comb begin
    state_d    = state_q;
    slot_d     = slot_q;
    phase_d    = phase_q;
    tap_d      = tap_q;
    accept     = (state_q == RR_IDLE) && in_valid;
    out_slot   = ((int'(slot_q) % M) == 0);
    last_phase = (phase_q == PHW'(L - 1));
    last_tap   = (tap_q == TW'(NPH - 1));
    slot_nx    = (slot_q == SW'(SLOTS - 1)) ? '0 : slot_q + SW'(1);
    case (state_q)
      RR_IDLE: begin
        if (in_valid) begin
          state_d = RR_SCAN;
          phase_d = '0;
        end
      end
      RR_SCAN: begin
        if (out_slot) begin
          state_d = RR_MAC;
          tap_d   = '0;
        end else begin
          slot_d = slot_nx;
          if (last_phase) state_d = RR_IDLE;
          else            phase_d = phase_q + PHW'(1);
        end
      end
      RR_MAC: begin
        if (last_tap) begin
          slot_d = slot_nx;
          if (last_phase) state_d = RR_IDLE;
          else begin
            state_d = RR_SCAN;
            phase_d = phase_q + PHW'(1);
          end
        end else begin
          tap_d = tap_q + TW'(1);
        end
      end
      default: state_d = RR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RR_IDLE;
      slot_q  <= '0;
      phase_q <= '0;
      tap_q   <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
      phase_q <= phase_d;
      tap_q   <= tap_d;
    end
  end

  assign phase     = phase_q;
  assign tap       = tap_q;
  assign mac_en    = (state_q == RR_MAC);
  assign mac_first = mac_en && (tap_q == '0);
  assign mac_last  = mac_en && last_tap;

  // an input always starts on a slot that is a multiple of L
  assert_accept_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ((int'(slot_q) % L) == 0))
    else $error("input accepted off an L boundary");

  // accepted input is followed by the first scan of its window
  assert_accept_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q == RR_SCAN && phase_q == '0))
    else $error("accepted input did not start a scan");

endmodule

// File: rtl/rr_history.sv
module rr_history
  import rr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NPH = 4,
  localparam int TW    = idx_w(NPH),
  localparam int TAP_N = 1 << TW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [DW-1:0]             din,
  output logic [TAP_N-1:0][DW-1:0]  hist
);

  logic [DW-1:0] stage_q [NPH];
  logic [DW-1:0] stage_d [NPH];

  always_comb begin
    for (int i = 0; i < NPH; i++) begin
      if (!shift_en)   stage_d[i] = stage_q[i];
      else if (i == 0) stage_d[i] = din;
      else             stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPH; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < NPH; i++) stage_q[i] <= stage_d[i];
    end
  end

  for (genvar g = 0; g < TAP_N; g++) begin : g_out
    if (g < NPH) begin : g_live
      assign hist[g] = stage_q[g];
    end else begin : g_pad
      assign hist[g] = '0;
    end
  end

endmodule

// File: rtl/rr_mac.sv
module rr_mac
  import rr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int L     = 3,
  parameter int NTAPS = 12,
  parameter int SHIFT = 15,
  parameter logic [NTAPS*CW-1:0] COEFS = '0,
  localparam int NPH   = (NTAPS + L - 1) / L,
  localparam int PHW   = idx_w(L),
  localparam int TW    = idx_w(NPH),
  localparam int PH_N  = 1 << PHW,
  localparam int TAP_N = 1 << TW,
  localparam int AW    = DW + CW + $clog2(NPH + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mac_en,
  input  logic                     mac_first,
  input  logic                     mac_last,
  input  logic [PHW-1:0]           phase,
  input  logic [TW-1:0]            tap,
  input  logic [TAP_N-1:0][DW-1:0] hist,
  output logic                     out_valid,
  output logic [DW-1:0]            out_data
);

  localparam logic signed [AW-1:0] RND    = AW'(1) << (SHIFT - 1);
  localparam logic signed [AW-1:0] SAT_HI = AW'((64'sd1 <<< (DW - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

  // polyphase view of the taps: branch p, term i holds tap p + i*L
  logic signed [CW-1:0] poly [PH_N][TAP_N];

  for (genvar gp = 0; gp < PH_N; gp++) begin : g_ph
    for (genvar gi = 0; gi < TAP_N; gi++) begin : g_term
      localparam int T = gp + gi * L;
      if (gp < L && gi < NPH && T < NTAPS) begin : g_tap
        assign poly[gp][gi] = COEFS[T*CW +: CW];
      end else begin : g_zero
        assign poly[gp][gi] = '0;
      end
    end
  end

  logic signed [CW-1:0]    coef;
  logic signed [DW-1:0]    smp;
  logic signed [DW+CW-1:0] prod;
  logic signed [AW-1:0]    acc_q, acc_d, acc_sum, rnd;
  logic [DW-1:0]           sat, out_data_d;
  logic                    out_valid_q;
  logic [DW-1:0]           out_data_q;

  always_comb begin
    coef    = poly[phase][tap];
    smp     = hist[tap];
    prod    = coef * smp;
    acc_sum = (mac_first ? '0 : acc_q) + AW'(prod);
    acc_d   = mac_en ? acc_sum : acc_q;
    rnd     = (acc_sum + RND) >>> SHIFT;
    if (rnd > SAT_HI)      sat = SAT_HI[DW-1:0];
    else if (rnd < SAT_LO) sat = SAT_LO[DW-1:0];
    else                   sat = rnd[DW-1:0];
    out_data_d = mac_last ? sat : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      acc_q       <= acc_d;
      out_valid_q <= mac_last;
      out_data_q  <= out_data_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

  // a continuing term must follow a term of the same dot product
  assert_term_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !mac_first) |-> $past(mac_en))
    else $error("accumulation continued without a preceding term");

  // outputs are isolated single-cycle strobes
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_q |=> !out_valid_q)
    else $error("output strobe lasted two cycles");

endmodule

// File: rtl/ratio_resampler.sv
module ratio_resampler
  import rr_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int L     = 3,
  parameter int M     = 2,
  parameter int NTAPS = 12,
  parameter int SHIFT = 15,
  parameter logic [NTAPS*CW-1:0] COEFS = {NTAPS{CW'(1) << (CW - 3)}},
  localparam int NPH     = (NTAPS + L - 1) / L,
  localparam int PHW     = idx_w(L),
  localparam int TW      = idx_w(NPH),
  localparam int TAP_N   = 1 << TW,
  localparam int OUT_MAX = (L + M - 1) / M
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q, rst_sync_d;
  logic       rst_n_i;

  assign rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= rst_sync_d;
  end

  assign rst_n_i = rst_sync_q[1];

  logic                     accept, mac_en, mac_first, mac_last;
  logic [PHW-1:0]           phase;
  logic [TW-1:0]            tap;
  logic [TAP_N-1:0][DW-1:0] hist;

  rr_seq #(.L(L), .M(M), .NPH(NPH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .in_valid  (in_valid),
    .accept    (accept),
    .phase     (phase),
    .tap       (tap),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .mac_last  (mac_last)
  );

  rr_history #(.DW(DW), .NPH(NPH)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .shift_en (accept),
    .din      (in_data),
    .hist     (hist)
  );

  rr_mac #(
    .DW(DW), .CW(CW), .L(L), .NTAPS(NTAPS), .SHIFT(SHIFT), .COEFS(COEFS)
  ) u_mac (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .mac_en    (mac_en),
    .mac_first (mac_first),
    .mac_last  (mac_last),
    .phase     (phase),
    .tap       (tap),
    .hist      (hist),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // outputs produced since the last accepted input, for the bound check
  localparam int OCW = $clog2(OUT_MAX + 2) + 1;
  logic [OCW-1:0] out_cnt_q, out_cnt_d;

  always_comb begin
    out_cnt_d = out_cnt_q;
    if (accept)         out_cnt_d = '0;
    else if (out_valid) out_cnt_d = out_cnt_q + OCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) out_cnt_q <= '0;
    else          out_cnt_q <= out_cnt_d;
  end

  assert_out_bound_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    int'(out_cnt_q) <= OUT_MAX)
    else $error("too many outputs for one input");

  assert_no_out_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    accept |=> !out_valid)
    else $error("output strobe right after an accepted input");

endmodule

// File: tb/ratio_resampler_bench.sv
module ratio_resampler_bench;

  typedef int iq_t[$];

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int L1 = 3, M1 = 2, N1 = 12;
  localparam int L2 = 2, M2 = 3, N2 = 7;
  // tap 0 in the low bits
  localparam logic [N1*CW-1:0] C1 = {16'sd0, 16'sd4000, 16'sd11000, 16'sd16384,
    16'sd28000, 16'sd32000, 16'sd28000, 16'sd16384, 16'sd11000, 16'sd4000,
    16'sd0, -16'sd1200};
  localparam logic [N2*CW-1:0] C2 = {16'sd3000, 16'sd9000, 16'sd20000,
    16'sd30000, 16'sd20000, 16'sd9000, 16'sd3000};
  // minimum spacing per R7, using the larger of the two converters
  localparam int GAP1 = L1 * ((N1 + L1 - 1) / L1 + 1) + 1;
  localparam int GAP2 = L2 * ((N2 + L2 - 1) / L2 + 1) + 1;
  localparam int GAP  = (GAP1 > GAP2) ? GAP1 : GAP2;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [DW-1:0] in_data;
  logic out_valid1, out_valid2;
  logic [DW-1:0] out_data1, out_data2;

  always #4 clk = ~clk;

  ratio_resampler #(.DW(DW), .CW(CW), .L(L1), .M(M1), .NTAPS(N1), .SHIFT(15),
    .COEFS(C1)) u_ratio_resampler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid1), .out_data(out_data1));

  ratio_resampler #(.DW(DW), .CW(CW), .L(L2), .M(M2), .NTAPS(N2), .SHIFT(15),
    .COEFS(C2)) u_ratio_resampler_dn (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid2), .out_data(out_data2));

  int   n_checks = 0;
  int   n_fails  = 0;
  iq_t  got1, got2;
  int   doubles = 0;
  logic prev1 = 1'b0, prev2 = 1'b0;
  int   lcg = 12345;

  const iq_t h1 = '{-1200, 0, 4000, 11000, 16384, 28000, 32000, 28000, 16384,
                    11000, 4000, 0};
  const iq_t h2 = '{3000, 9000, 20000, 30000, 20000, 9000, 3000};

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid1) got1.push_back(int'($signed(out_data1)));
      if (out_valid2) got2.push_back(int'($signed(out_data2)));
      if ((out_valid1 && prev1) || (out_valid2 && prev2)) doubles++;
      prev1 = out_valid1;
      prev2 = out_valid2;
    end else begin
      prev1 = 1'b0;
      prev2 = 1'b0;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic iq_t ref_model(iq_t xs, iq_t h, int l, int m);
    iq_t xu, y;
    longint acc, r;
    foreach (xs[k]) begin
      for (int p = 0; p < l; p++) xu.push_back((p == 0) ? xs[k] : 0);
    end
    for (int n = 0; n < xu.size(); n += m) begin
      acc = 0;
      for (int j = 0; j < h.size(); j++) begin
        if (n - j >= 0) acc += longint'(h[j]) * longint'(xu[n - j]);
      end
      r = (acc + (longint'(1) <<< 14)) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      y.push_back(int'(r));
    end
    return y;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    got1.delete();
    got2.delete();
  endtask

  task automatic run_case(iq_t xs, iq_t gaps, int junk_idx);
    int w;
    do_reset();
    foreach (xs[k]) begin
      in_valid = 1'b1;
      in_data  = DW'(xs[k]);
      @(negedge clk);
      in_valid = 1'b0;
      w = gaps[k] - 1;
      if (k == junk_idx) begin
        in_valid = 1'b1;
        in_data  = 16'sh7abc;
        @(negedge clk);
        in_valid = 1'b0;
        w = gaps[k] - 2;
      end
      repeat (w) @(negedge clk);
    end
    repeat (60) @(negedge clk);
  endtask

  task automatic verify(string req, string tag, iq_t exp, iq_t got);
    int n;
    chk(got.size() == exp.size(), "R4", {tag, " output count"}, got.size(), exp.size());
    n = (got.size() < exp.size()) ? got.size() : exp.size();
    for (int i = 0; i < n; i++)
      chk(got[i] == exp[i], req, $sformatf("%s sample %0d", tag, i), got[i], exp[i]);
  endtask

  task automatic run_and_verify(string req, iq_t xs, iq_t gaps, int junk_idx);
    run_case(xs, gaps, junk_idx);
    verify(req, "up3/dn2", ref_model(xs, h1, L1, M1), got1);
    verify(req, "up2/dn3", ref_model(xs, h2, L2, M2), got2);
  endtask

  function automatic iq_t even_gaps(int n);
    iq_t g;
    for (int i = 0; i < n; i++) g.push_back(GAP);
    return g;
  endfunction

  function automatic int next_rand();
    lcg = lcg * 1103515245 + 12345;
    return ((lcg >>> 8) & 32'hffff) - 32768;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    @(negedge clk);
    chk(out_valid1 == 1'b0 && out_valid2 == 1'b0, "R1", "valid in reset",
        {out_valid1, out_valid2}, 0);
    chk(out_data1 == '0 && out_data2 == '0, "R1", "data in reset",
        out_data1 | out_data2, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(out_valid1 == 1'b0 && out_valid2 == 1'b0, "R1", "valid after reset",
        {out_valid1, out_valid2}, 0);
  endtask

  // R2 R3: an impulse reproduces every M-th tap, starting at tap 0
  task automatic t_impulse(int a);
    iq_t xs;
    xs.push_back(a);
    for (int i = 0; i < 6; i++) xs.push_back(0);
    run_and_verify("R2", xs, even_gaps(xs.size()), -1);
  endtask

  // R5: unit impulses land on exact halves of tap 4 and tap 8
  task automatic t_rounding();
    iq_t xs;
    xs = '{1, 0, 0, 0, 0};
    run_and_verify("R5", xs, even_gaps(xs.size()), -1);
    xs = '{-1, 0, 0, 0, 0};
    run_and_verify("R5", xs, even_gaps(xs.size()), -1);
  endtask

  task automatic t_random();
    iq_t xs;
    for (int i = 0; i < 40; i++) xs.push_back(next_rand());
    run_and_verify("R8", xs, even_gaps(xs.size()), -1);
  endtask

  task automatic t_saturate();
    iq_t xs;
    for (int i = 0; i < 8; i++) xs.push_back(32767);
    for (int i = 0; i < 8; i++) xs.push_back(-32768);
    run_and_verify("R6", xs, even_gaps(xs.size()), -1);
  endtask

  task automatic t_gaps();
    iq_t xs, g;
    for (int i = 0; i < 12; i++) xs.push_back(next_rand());
    g = '{GAP, 37, GAP + 1, 90, 21, GAP, 55, GAP, 200, 19, GAP + 3, GAP};
    run_and_verify("R10", xs, g, -1);
  endtask

  task automatic t_ignored();
    iq_t xs;
    for (int i = 0; i < 10; i++) xs.push_back(next_rand());
    run_and_verify("R7", xs, even_gaps(xs.size()), 0);
    run_and_verify("R7", xs, even_gaps(xs.size()), 5);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    t_reset();
    t_impulse(20000);
    t_impulse(-12345);
    t_rounding();
    t_random();
    t_saturate();
    t_gaps();
    t_ignored();
    chk(doubles == 0, "R9", "back-to-back output strobes", doubles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule